// File: doc/BRIEF.md
# Programmable Two-Port Trace Replicator

The block takes a single trace stream with a valid/ready handshake and copies every beat to two output branches. Each branch sits behind an 8-bit gate value held in a small memory-mapped register bank. A gate of zero opens the branch. Any other value shuts it. A shut branch drops out of the handshake entirely, so a sink that nobody reads cannot push back on the shared source.

When both branches are open, the input beat is held until each branch has taken it. The two branches may accept in different cycles. A per-branch "already delivered" flag makes sure neither branch sees the same beat twice. When both branches are shut, beats are accepted and thrown away, so the source never stalls.

Gate writes only land while the bank is unlocked. Software unlocks it with a key word, programs the gates, and then relocks it. A fixed identification word can be read back so software can recognise the block.

Top module: `tfan_fanout`

## Requirements
- R1: After reset both gates read 0xFF, the bank is locked (status bit0 = 1), no output is valid and in_ready is 1.
- R2: An open branch (gate value 0x00) presents every accepted input beat exactly once, in input order, with data equal to the input data.
- R3: A branch whose gate value is non-zero never asserts out_valid, and its out_ready has no effect on in_ready.
- R4: While any open branch that has not yet taken the current beat has out_ready low, in_ready stays low.
- R5: A branch that took the current beat before the other branch deasserts out_valid until the next input beat arrives.
- R6: With both gates non-zero, in_ready is 1 in every cycle and no output becomes valid.
- R7: Gate writes while the bank is locked are ignored, and the read-back value stays unchanged.
- R8: Writing 0xC5ACCE55 to offset 0xFB0 unlocks the bank. Any other value written there locks it. Offset 0xFB4 bit0 reads 1 when locked and 0 when unlocked.
- R9: Offset 0xFE0 reads the identification word 0x0003B909, which matches under mask 0x0003FFFF. Writes to it have no effect.
- R10: A gate register reads back the full 8-bit value last written while unlocked, including non-zero values other than 0xFF, and every such value shuts the branch.
- R11: The gate for output 0 sits at offset 0x000 and the gate for output 1 at offset 0x004. A write to one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle when in_valid is high |
| in_data | input | DATA_W | Input beat payload |
| out_valid | output | NUM_OUT | Per-branch beat present |
| out_ready | input | NUM_OUT | Per-branch sink ready |
| out_data | output | NUM_OUT*DATA_W | Per-branch payload, branch i at bits i*DATA_W upward |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
Two things can land in the same cycle: one branch finishing its handshake, and the other branch holding the input stalled. The bench provokes this by opening both branches and holding one sink not ready while the other accepts. It then releases the stalled sink. The scoreboard pops one expected beat per branch handshake, so a second delivery to the early branch shows up as a pop from an empty queue. The port checks confirm that in_ready stayed low until the late branch accepted.

// File: rtl/tfan_pkg.sv
package tfan_pkg;
   localparam int unsigned   TFAN_GATE_W      = 8;
   localparam int unsigned   TFAN_GATE_STRIDE = 4;
   localparam int unsigned   TFAN_KEY_OFS     = 'hFB0;
   localparam int unsigned   TFAN_STAT_OFS    = 'hFB4;
   localparam int unsigned   TFAN_ID_OFS      = 'hFE0;
   localparam logic [31:0]   TFAN_UNLOCK_KEY  = 32'hC5ACCE55;
   localparam logic [TFAN_GATE_W-1:0] TFAN_GATE_PASS = '0;
   localparam logic [TFAN_GATE_W-1:0] TFAN_GATE_SHUT = '1;
endpackage

// File: rtl/tfan_regs.sv
module tfan_regs
   import tfan_pkg::*;
#(
   parameter int unsigned NUM_OUT  = 2,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [31:0] ID_VALUE = 32'h0003B909
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic [NUM_OUT-1:0] branch_open
);
   localparam logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(TFAN_KEY_OFS);
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(TFAN_STAT_OFS);
   localparam logic [ADDR_W-1:0] ID_ADDR   = ADDR_W'(TFAN_ID_OFS);

   logic                           locked_q;
   logic [NUM_OUT*TFAN_GATE_W-1:0] gate_flat;
   logic                           key_hit;

   assign key_hit = reg_wr && (reg_addr == KEY_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)       locked_q <= 1'b1;
      else if (key_hit) locked_q <= (reg_wdata != TFAN_UNLOCK_KEY);
   end

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
      localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(g * TFAN_GATE_STRIDE);
      logic [TFAN_GATE_W-1:0] val_q;
      logic                   hit;
      assign hit = reg_wr && !locked_q && (reg_addr == GATE_ADDR);
      always_ff @(posedge clk) begin
         if (!rst_n)   val_q <= TFAN_GATE_SHUT;
         else if (hit) val_q <= reg_wdata[TFAN_GATE_W-1:0];
      end
      assign gate_flat[g*TFAN_GATE_W +: TFAN_GATE_W] = val_q;
      assign branch_open[g] = (val_q == TFAN_GATE_PASS);

      // R7
      locked_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && locked_q && reg_addr == GATE_ADDR) |=> $stable(val_q));
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < int'(NUM_OUT); i++) begin
         if (reg_addr == ADDR_W'(i * TFAN_GATE_STRIDE))
            reg_rdata = 32'(gate_flat[i*TFAN_GATE_W +: TFAN_GATE_W]);
      end
      if (reg_addr == STAT_ADDR) reg_rdata = {31'b0, locked_q};
      if (reg_addr == ID_ADDR)   reg_rdata = ID_VALUE;
   end

   // R8
   unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit && reg_wdata == TFAN_UNLOCK_KEY) |=> !locked_q);
   // R8
   relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit && reg_wdata != TFAN_UNLOCK_KEY) |=> locked_q);
endmodule

// File: rtl/tfan_branch.sv
module tfan_branch (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic in_valid_i,
   input  logic fire_i,
   input  logic out_ready_i,
   output logic out_valid_o,
   output logic done_o
);
   logic taken_q;

   assign out_valid_o = in_valid_i && open_i && !taken_q;
   assign done_o      = !open_i || taken_q || out_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n)                        taken_q <= 1'b0;
      else if (fire_i || !open_i)        taken_q <= 1'b0;
      else if (out_valid_o && out_ready_i) taken_q <= 1'b1;
   end

   // R5
   no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && !fire_i) |=> !out_valid_o);
endmodule

// File: rtl/tfan_fanout.sv
module tfan_fanout
   import tfan_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_OUT  = 2,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [31:0] ID_VALUE = 32'h0003B909
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [DATA_W-1:0]         in_data,
   output logic [NUM_OUT-1:0]        out_valid,
   input  logic [NUM_OUT-1:0]        out_ready,
   output logic [NUM_OUT*DATA_W-1:0] out_data,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata
);
   if (NUM_OUT < 1 || NUM_OUT > 16) begin : g_bad_count
      $error("tfan_fanout: NUM_OUT out of range");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("tfan_fanout: ADDR_W too narrow for register map");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("tfan_fanout: DATA_W must be positive");
   end

   logic [NUM_OUT-1:0] branch_open;
   logic [NUM_OUT-1:0] branch_done;
   logic               fire;

   tfan_regs #(
      .NUM_OUT  (NUM_OUT),
      .ADDR_W   (ADDR_W),
      .ID_VALUE (ID_VALUE)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .branch_open (branch_open)
   );

   assign in_ready = &branch_done;
   assign fire     = in_valid && in_ready;

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_br
      tfan_branch u_branch (
         .clk         (clk),
         .rst_n       (rst_n),
         .open_i      (branch_open[g]),
         .in_valid_i  (in_valid),
         .fire_i      (fire),
         .out_ready_i (out_ready[g]),
         .out_valid_o (out_valid[g]),
         .done_o      (branch_done[g])
      );
      assign out_data[g*DATA_W +: DATA_W] = in_data;

      // R3
      shut_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !branch_open[g] |-> !out_valid[g]);
      // R4
      join_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fire && out_valid[g]) |-> out_ready[g]);
   end

   // R6
   all_shut_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (branch_open == '0) |-> (in_ready && out_valid == '0));
endmodule

// File: tb/tfan_fanout_bench.sv
`timescale 1ns/1ps
module tfan_fanout_bench;
   localparam int DW = 32;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic [1:0]    out_valid;
   logic [1:0]    out_ready = 2'b11;
   logic [2*DW-1:0] out_data;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;

   int  checks = 0;
   int  failures = 0;
   bit  running = 1'b0;
   bit  finished = 1'b0;
   bit  open_m [2] = '{1'b0, 1'b0};
   int  rdy_mode = 0;   // 0 all ready, 1 random, 2 manual
   logic [15:0] lfsr = 16'hACE1;
   logic [DW-1:0] exp_q0 [$];
   logic [DW-1:0] exp_q1 [$];
   logic [31:0] rd;

   always #4 clk = ~clk;

   tfan_fanout #(.DATA_W(DW), .NUM_OUT(2), .ADDR_W(AW)) u_tfan_fanout (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rdy_mode == 0) out_ready = 2'b11;
      else if (rdy_mode == 1) out_ready = {lfsr[3], lfsr[7]};
   end

   // scoreboard monitor
   always @(negedge clk) begin
      #1;
      if (rst_n && running) begin
         for (int i = 0; i < 2; i++) begin
            logic [DW-1:0] got;
            logic [DW-1:0] want;
            got = out_data[i*DW +: DW];
            if (in_valid && !open_m[i]) chk(!out_valid[i], "R3 shut branch valid", 64'(out_valid[i]), 64'd0);
            if (out_valid[i] && out_ready[i]) begin
               if ((i == 0 ? exp_q0.size() : exp_q1.size()) == 0) begin
                  chk(1'b0, "R5 repeated or unexpected beat", 64'(got), 64'd0);
               end else begin
                  want = (i == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
                  chk(got == want, "R2 branch data", 64'(got), 64'(want));
               end
            end
         end
      end
   end

   task automatic reg_write(input int a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input int a, output logic [31:0] d);
      reg_addr = AW'(a);
      #1 d = reg_rdata;
   endtask

   task automatic send_beat(input logic [DW-1:0] d);
      in_valid = 1'b1; in_data = d;
      if (open_m[0]) exp_q0.push_back(d);
      if (open_m[1]) exp_q1.push_back(d);
      forever begin
         #1;
         if (in_ready) break;
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;
      // R1 reset state
      #1;
      chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
      chk(out_valid == 2'b00, "R1 out_valid after reset", 64'(out_valid), 64'd0);
      reg_read('h000, rd); chk(rd == 32'hFF, "R1 gate0 reset", 64'(rd), 64'hFF);
      reg_read('h004, rd); chk(rd == 32'hFF, "R1 gate1 reset", 64'(rd), 64'hFF);
      reg_read('hFB4, rd); chk(rd[0] == 1'b1, "R1 locked after reset", 64'(rd[0]), 64'd1);
      @(negedge clk);

      // R9 identification
      reg_read('hFE0, rd);
      chk((rd & 32'h0003FFFF) == 32'h0003B909, "R9 id masked", 64'(rd), 64'h3B909);
      @(negedge clk);
      reg_write('hFE0, 32'h0);
      reg_read('hFE0, rd); chk(rd == 32'h0003B909, "R9 id after write", 64'(rd), 64'h3B909);
      @(negedge clk);

      // R7 locked write ignored
      reg_write('h000, 32'h0);
      reg_read('h000, rd); chk(rd == 32'hFF, "R7 locked gate0 write", 64'(rd), 64'hFF);
      @(negedge clk);
      for (int k = 0; k < 4; k++) send_beat(DW'(32'h100 + k));

      // R8 unlock
      reg_write('hFB0, 32'hC5ACCE55);
      reg_read('hFB4, rd); chk(rd[0] == 1'b0, "R8 unlocked status", 64'(rd[0]), 64'd0);
      @(negedge clk);
      reg_write('h000, 32'h00); open_m[0] = 1'b1;
      reg_write('h004, 32'h5A);
      // R11 / R10
      reg_read('h000, rd); chk(rd == 32'h00, "R11 gate0 offset", 64'(rd), 64'h0);
      reg_read('h004, rd); chk(rd == 32'h5A, "R10 gate1 readback", 64'(rd), 64'h5A);
      @(negedge clk);

      // R3 blocked branch ready ignored
      rdy_mode = 2; out_ready = 2'b01;
      in_valid = 1'b1; in_data = 32'hBEEF0001; exp_q0.push_back(32'hBEEF0001);
      #1 chk(in_ready == 1'b1, "R3 shut branch ready ignored", 64'(in_ready), 64'd1);
      @(negedge clk); in_valid = 1'b0;

      // R2 one branch open, random ready
      rdy_mode = 1;
      for (int k = 0; k < 12; k++) send_beat(DW'(32'hA000 + k * 3));

      // R2 both open, random ready
      reg_write('h004, 32'h00); open_m[1] = 1'b1;
      for (int k = 0; k < 24; k++) send_beat(DW'(32'hC000 ^ (k * 32'h1111)));
      repeat (2) @(negedge clk);

      // R4 / R5 branch 0 takes early, branch 1 stalls
      rdy_mode = 2; out_ready = 2'b01;
      in_valid = 1'b1; in_data = 32'h5151_5151;
      exp_q0.push_back(32'h5151_5151); exp_q1.push_back(32'h5151_5151);
      #1 chk(in_ready == 1'b0, "R4 stall with branch1 not ready", 64'(in_ready), 64'd0);
      @(negedge clk);
      #1 chk(out_valid[0] == 1'b0, "R5 branch0 holds off after taking", 64'(out_valid[0]), 64'd0);
      chk(in_ready == 1'b0, "R4 still stalled", 64'(in_ready), 64'd0);
      @(negedge clk);
      out_ready = 2'b10;
      #1 chk(in_ready == 1'b1, "R4 released by late branch", 64'(in_ready), 64'd1);
      chk(out_valid == 2'b10, "R5 only late branch valid", 64'(out_valid), 64'b10);
      @(negedge clk); in_valid = 1'b0;
      rdy_mode = 0;
      @(negedge clk);

      // R8 wrong key relocks, R7 write ignored
      reg_write('hFB0, 32'h1234_5678);
      reg_read('hFB4, rd); chk(rd[0] == 1'b1, "R8 wrong key relocks", 64'(rd[0]), 64'd1);
      @(negedge clk);
      reg_write('h000, 32'h77);
      reg_read('h000, rd); chk(rd == 32'h00, "R7 relocked gate0 unchanged", 64'(rd), 64'h0);
      @(negedge clk);

      // R6 both shut
      reg_write('hFB0, 32'hC5ACCE55);
      reg_write('h000, 32'hFF); open_m[0] = 1'b0;
      reg_write('h004, 32'h80); open_m[1] = 1'b0;
      reg_write('hFB0, 32'h0);
      rdy_mode = 2; out_ready = 2'b00;
      for (int k = 0; k < 5; k++) begin
         in_valid = 1'b1; in_data = DW'(32'hD00 + k);
         #1 chk(in_ready == 1'b1 && out_valid == 2'b00, "R6 discard flow",
                64'({in_ready, out_valid}), 64'b100);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (3) @(negedge clk);

      chk(exp_q0.size() == 0, "R2 branch0 all delivered", 64'(exp_q0.size()), 64'd0);
      chk(exp_q1.size() == 0, "R2 branch1 all delivered", 64'(exp_q1.size()), 64'd0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule